// File: doc/BRIEF.md
# UART Shared Data Register and Receive Status Logic

This block is the processor-facing register layer of one serial channel. A single bus address reaches two separate storage elements. A read of that address returns the most recently received character. A write to it loads the transmit holding register. A second, 16-bit status/control register reports whether a character is waiting. It also reports three sticky receive error conditions and the transmit holding state. Through the same register, software sets the receive interrupt enable and the character length, and clears the errors.

A receive shifter outside this block presents each finished character as a one-cycle strobe. The strobe carries the character's data and its parity and framing indications. A transmit shifter outside the block takes the holding register through a load strobe and an accept handshake. The interrupt output is a level. It stays high while an enabled receive event is pending.

Top module: `uart_dreg_status`

## Requirements
- R1: A pulse on `data_rd` returns the receive buffer on `rdata`. A pulse on `data_wr` stores `wdata` in a separate transmit holding register, shown on `tx_data` one cycle later. A data write never changes `rdata`.
- R2: When `rx_valid` is high and the receive-full flag (status bit 12) is clear, the character on `rx_data` is placed in the receive buffer. The full flag reads 1 from the next cycle.
- R3: `data_rd` without `rx_valid` clears the full flag in the next cycle. When `data_rd` and `rx_valid` are high together, the new character is stored and the flag stays 1.
- R4: When `rx_valid` arrives while the full flag is set and `data_rd` is low, the overrun flag (status bit 14) is set and the receive buffer keeps the older character.
- R5: A stored character with `rx_perr` high sets the parity flag (status bit 15). One with `rx_ferr` high sets the framing flag (status bit 13).
- R6: The three error flags stay set across data reads. A status write with bit 8 set clears them. An error arriving in the same cycle as the clear wins. Bit 8 always reads 0.
- R7: A status write stores bit 0 as the 7-bit length select. While it is 1, `rdata[7]` reads 0 and bits 6..0 are unchanged.
- R8: A status write stores bit 9 as the receive interrupt enable. `irq` equals that enable ANDed with the OR of the full flag and the three error flags.
- R9: A data write drives `tx_load` high for exactly the next cycle and clears the transmit-empty flag (status bit 11). `tx_accept` without a concurrent data write sets that flag again.
- R10: After reset the status register reads 16'h0800, `irq` is 0, `tx_load` is 0 and `tx_data` is 0. The receive buffer content is not defined until the first character is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_rd | input | 1 | Bus read strobe of the shared data address |
| data_wr | input | 1 | Bus write strobe of the shared data address |
| wdata | input | 8 | Write data for the transmit holding register |
| rdata | output | 8 | Receive buffer readback, masked in 7-bit mode |
| sts_wr | input | 1 | Bus write strobe of the status/control register |
| sts_wdata | input | 16 | Status write data: bit 9 enable, bit 8 error clear, bit 0 length |
| sts_rdata | output | 16 | Status readback: 15 parity, 14 overrun, 13 framing, 12 full, 11 tx empty, 9 enable, 0 length |
| rx_valid | input | 1 | One-cycle strobe from the receive shifter: character complete |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error indication of the character |
| rx_ferr | input | 1 | Framing error indication of the character |
| tx_load | output | 1 | One-cycle strobe to the transmit shifter: holding register loaded |
| tx_data | output | 8 | Transmit holding register contents |
| tx_accept | input | 1 | Transmit shifter has taken the holding register |
| irq | output | 1 | Receive interrupt request, level |

## Verification
All receive state is visible at the ports. A wrong full flag or error flag shows up in `sts_rdata` and in `irq` in the cycle right after the strobe that should have changed it. A lost or overwritten character shows on `rdata` in that same cycle. The length mask and the interrupt level are combinational over the stored state, so a fault in either one is visible within the cycle in which the state or the control bit changes. A transmit side fault shows as a missing, doubled or late `tx_load` pulse, or as a transmit-empty bit that does not follow the write/accept handshake.

// File: rtl/udr_pkg.sv
package udr_pkg;
    localparam int DATA_W = 8;
    localparam int STS_W  = 16;

    localparam int B_PAR  = 15;
    localparam int B_OVR  = 14;
    localparam int B_FRM  = 13;
    localparam int B_FULL = 12;
    localparam int B_TXE  = 11;
    localparam int B_RIE  = 9;
    localparam int B_ECLR = 8;
    localparam int B_LEN7 = 0;

    typedef struct packed {
        logic [DATA_W-1:0] rbuf;
        logic              full;
        logic              par;
        logic              ovr;
        logic              frm;
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              load;
        logic              empty;
    } tx_state_t;

    typedef struct packed {
        logic rie;
        logic len7;
    } ctl_state_t;
endpackage

// File: rtl/udr_rx_path.sv
module udr_rx_path
    import udr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              take,
    input  logic              err_clr,
    output rx_state_t         st
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first so that a same-cycle error still lands
        if (err_clr) begin
            st_d.par = 1'b0;
            st_d.ovr = 1'b0;
            st_d.frm = 1'b0;
        end
        if (rx_valid) begin
            if (!st_q.full || take) begin
                st_d.rbuf = rx_data;
                st_d.full = 1'b1;
                if (rx_perr) st_d.par = 1'b1;
                if (rx_ferr) st_d.frm = 1'b1;
            end else begin
                st_d.ovr = 1'b1;
            end
        end else if (take) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/udr_tx_path.sv
module udr_tx_path
    import udr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accept,
    output tx_state_t         st
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = wr;
        if (wr) begin
            st_d.hold  = wdata;
            st_d.empty = 1'b0;
        end else if (accept) begin
            st_d.empty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/udr_ctl.sv
module udr_ctl
    import udr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [STS_W-1:0] wdata,
    output ctl_state_t       st,
    output logic             err_clr
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.rie  = wdata[B_RIE];
            st_d.len7 = wdata[B_LEN7];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st      = st_q;
    assign err_clr = wr & wdata[B_ECLR];
endmodule

// File: rtl/uart_dreg_status.sv
module uart_dreg_status
    import udr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sts_wr,
    input  logic [STS_W-1:0]  sts_wdata,
    output logic [STS_W-1:0]  sts_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_accept,
    output logic              irq
);
    rx_state_t  rx_st;
    tx_state_t  tx_st;
    ctl_state_t ctl_st;
    logic       err_clr;

    udr_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(sts_wr), .wdata(sts_wdata),
        .st(ctl_st), .err_clr(err_clr)
    );

    udr_rx_path u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .take(data_rd),
        .err_clr(err_clr), .st(rx_st)
    );

    udr_tx_path u_tx (
        .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(wdata),
        .accept(tx_accept), .st(tx_st)
    );

    always_comb begin
        rdata = rx_st.rbuf;
        if (ctl_st.len7) rdata[DATA_W-1] = 1'b0;
    end

    always_comb begin
        sts_rdata         = '0;
        sts_rdata[B_PAR]  = rx_st.par;
        sts_rdata[B_OVR]  = rx_st.ovr;
        sts_rdata[B_FRM]  = rx_st.frm;
        sts_rdata[B_FULL] = rx_st.full;
        sts_rdata[B_TXE]  = tx_st.empty;
        sts_rdata[B_RIE]  = ctl_st.rie;
        sts_rdata[B_LEN7] = ctl_st.len7;
    end

    assign tx_load = tx_st.load;
    assign tx_data = tx_st.hold;
    assign irq     = ctl_st.rie & (rx_st.full | rx_st.par | rx_st.ovr | rx_st.frm);
endmodule

// File: rtl/udr_checker.sv
module udr_checker
    import udr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              data_rd,
    input logic              data_wr,
    input logic [DATA_W-1:0] rdata,
    input logic              sts_wr,
    input logic [STS_W-1:0]  sts_wdata,
    input logic [STS_W-1:0]  sts_rdata,
    input logic              rx_valid,
    input logic              tx_load,
    input logic              tx_accept,
    input logic              irq
);
    AST_FULL_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !sts_rdata[B_FULL] |=> sts_rdata[B_FULL]); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !rx_valid |=> !sts_rdata[B_FULL]); // R3

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && sts_rdata[B_FULL] && !data_rd && !sts_wr
        |=> sts_rdata[B_OVR] && $stable(rdata)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdata[B_PAR] && !sts_wr |=> sts_rdata[B_PAR]); // R6

    AST_LEN7_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdata[B_LEN7] |-> !rdata[DATA_W-1]); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_rdata[B_RIE] |-> !irq); // R8

    AST_TX_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> tx_load && !sts_rdata[B_TXE]); // R9

    AST_TX_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(data_wr)); // R9

    AST_TXE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_accept && !data_wr |=> sts_rdata[B_TXE]); // R9
endmodule

bind uart_dreg_status udr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .data_wr(data_wr),
    .rdata(rdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .sts_rdata(sts_rdata), .rx_valid(rx_valid), .tx_load(tx_load),
    .tx_accept(tx_accept), .irq(irq)
);

// File: tb/uart_dreg_status_tb_top.sv
`timescale 1ns/1ps
module uart_dreg_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_rd = 0, data_wr = 0, sts_wr = 0;
    logic [7:0]  wdata = 0, rx_data = 0;
    logic [15:0] sts_wdata = 0;
    logic        rx_valid = 0, rx_perr = 0, rx_ferr = 0, tx_accept = 0;
    logic [7:0]  rdata, tx_data;
    logic [15:0] sts_rdata;
    logic        tx_load, irq;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int m_buf = 0;
    bit m_full = 0, m_par = 0, m_ovr = 0, m_frm = 0, m_seen = 0;
    bit m_rie = 0, m_len7 = 0, m_load = 0, m_empty = 1;
    int m_hold = 0;

    always #4 clk = ~clk;

    uart_dreg_status dut_i (
        .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .data_wr(data_wr),
        .wdata(wdata), .rdata(rdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .sts_rdata(sts_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .tx_load(tx_load),
        .tx_data(tx_data), .tx_accept(tx_accept), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_sts;
        int exp_rd;
        exp_sts = (m_par << 15) | (m_ovr << 14) | (m_frm << 13) | (m_full << 12)
                | (m_empty << 11) | (m_rie << 9) | int'(m_len7);
        chk(sts_rdata[12] == m_full, "R2 R3 full flag", sts_rdata[12], m_full);
        chk(sts_rdata[14] == m_ovr, "R4 overrun flag", sts_rdata[14], m_ovr);
        chk(sts_rdata[15] == m_par && sts_rdata[13] == m_frm, "R5 R6 parity/framing flags",
            {sts_rdata[15], sts_rdata[13]}, {m_par, m_frm});
        chk(sts_rdata[11] == m_empty, "R9 tx empty flag", sts_rdata[11], m_empty);
        chk(int'(sts_rdata) == exp_sts, "R6 R7 R8 status word", sts_rdata, exp_sts);
        chk(irq == (m_rie & (m_full | m_par | m_ovr | m_frm)), "R8 irq level", irq,
            m_rie & (m_full | m_par | m_ovr | m_frm));
        chk(tx_load == m_load, "R9 tx_load pulse", tx_load, m_load);
        chk(int'(tx_data) == m_hold, "R1 tx holding data", tx_data, m_hold);
        if (m_seen) begin
            exp_rd = m_len7 ? (m_buf & 8'h7f) : m_buf;
            chk(int'(rdata) == exp_rd, "R1 R4 R7 receive readback", rdata, exp_rd);
        end
    endtask

    task automatic model_update();
        if (sts_wr && sts_wdata[8]) begin
            m_par = 0; m_ovr = 0; m_frm = 0;
        end
        if (sts_wr) begin
            m_rie  = sts_wdata[9];
            m_len7 = sts_wdata[0];
        end
        if (rx_valid) begin
            if (!m_full || data_rd) begin
                m_buf = rx_data; m_full = 1; m_seen = 1;
                if (rx_perr) m_par = 1;
                if (rx_ferr) m_frm = 1;
            end else begin
                m_ovr = 1;
            end
        end else if (data_rd) begin
            m_full = 0;
        end
        m_load = data_wr;
        if (data_wr) begin
            m_hold = wdata; m_empty = 0;
        end else if (tx_accept) begin
            m_empty = 1;
        end
    endtask

    // inputs already driven at the falling edge; advance one cycle, then compare
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        data_rd = 0; data_wr = 0; sts_wr = 0; rx_valid = 0;
        rx_perr = 0; rx_ferr = 0; tx_accept = 0; sts_wdata = 0;
    endtask

    task automatic rx_char(input logic [7:0] d, input bit p, input bit f);
        rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        chk(sts_rdata == 16'h0800, "R10 status after reset", sts_rdata, 16'h0800);
        chk(irq == 0 && tx_load == 0, "R10 irq/tx_load after reset", {irq, tx_load}, 0);
        chk(tx_data == 0, "R10 tx_data after reset", tx_data, 0);
        rst_n = 1;
        @(negedge clk);

        // R8 enable interrupt, R2 first character
        sts_wr = 1; sts_wdata = 16'h0200; step();
        rx_char(8'hA5, 0, 0); step();
        chk(irq == 1, "R8 irq with full and enable", irq, 1);
        // R1 data write does not touch receive buffer
        data_wr = 1; wdata = 8'h3C; step();
        chk(rdata == 8'hA5, "R1 rdata after data write", rdata, 8'hA5);
        tx_accept = 1; step();
        // R4 overrun keeps older character
        rx_char(8'h11, 0, 0); step();
        chk(rdata == 8'hA5 && sts_rdata[14], "R4 overrun keeps old data", rdata, 8'hA5);
        // R3 read clears full; R6 overrun persists
        data_rd = 1; step();
        chk(sts_rdata[14] == 1, "R6 overrun sticky over read", sts_rdata[14], 1);
        chk(irq == 1, "R8 irq held by error flag", irq, 1);
        // R5 parity and framing
        rx_char(8'hFF, 1, 0); step();
        data_rd = 1; rx_char(8'h80, 0, 1); step();
        chk(sts_rdata[12] == 1 && rdata == 8'h80, "R3 read plus new char keeps full", rdata, 8'h80);
        // R7 seven-bit length
        sts_wr = 1; sts_wdata = 16'h0201; step();
        chk(rdata == 8'h00, "R7 bit 7 masked", rdata, 8'h00);
        // R6 clear with simultaneous new error: error wins
        data_rd = 1; step();
        sts_wr = 1; sts_wdata = 16'h0301; rx_char(8'h7E, 1, 0); step();
        chk(sts_rdata[15] == 1 && sts_rdata[14] == 0 && sts_rdata[13] == 0,
            "R6 clear with concurrent parity", sts_rdata[15:13], 3'b100);
        sts_wr = 1; sts_wdata = 16'h0100; step();
        chk(sts_rdata[15:13] == 0 && sts_rdata[8] == 0, "R6 errors cleared", sts_rdata, 16'h1800);
        // R9 write and accept together
        data_wr = 1; wdata = 8'h5A; tx_accept = 1; step();
        chk(sts_rdata[11] == 0, "R9 write beats accept", sts_rdata[11], 0);
        step();
        chk(tx_load == 0, "R9 tx_load lasts one cycle", tx_load, 0);

        // mixed traffic
        for (int i = 0; i < 2000; i++) begin
            data_rd   = ($urandom % 3) == 0;
            data_wr   = ($urandom % 5) == 0;
            wdata     = 8'($urandom);
            tx_accept = ($urandom % 4) == 0;
            if (($urandom % 3) == 0) rx_char(8'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0);
            if (($urandom % 16) == 0) begin
                sts_wr = 1;
                sts_wdata = 16'($urandom);
            end
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule